// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the control unit of a single-cycle processor that runs a small six-instruction integer subset. It looks at the instruction's major opcode, at the function field (used only by register-format instructions) and at the ALU's zero flag. From these it drives every control point of the datapath in the same cycle. The outputs are the destination-register choice, the ALU operand-B choice, the writeback-source choice, the register and memory write enables, the immediate extension mode, a two-bit ALU operation and the next-PC select.

Each of the six instructions is recognised on its own, and each one maps to a complete control word. Register-format instructions are not grouped into one class that some other ALU decoder then has to resolve. The branch's next-PC select is formed inside the block by combining the branch decode with the zero flag. Any encoding outside the subset yields a quiet word in which no register, memory or PC update can take place. The block has no state and no clock.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 0x00 with funct 0x21 (add) drives reg_dst=1, alu_src=0, mem_to_reg=0, reg_wr=1, mem_wr=0, ext_sign=0, alu_op=2'b00 and pc_sel=0. The alu_op codes are 00 for add, 01 for subtract and 10 for OR.
- R2: Opcode 0x00 with funct 0x23 (subtract) drives the same word as R1, except that alu_op=2'b01.
- R3: Opcode 0x0D (OR-immediate) drives reg_dst=0, alu_src=1, mem_to_reg=0, reg_wr=1, mem_wr=0, ext_sign=0 (zero extension), alu_op=2'b10 and pc_sel=0.
- R4: Opcode 0x23 (load) drives reg_dst=0, alu_src=1, mem_to_reg=1, reg_wr=1, mem_wr=0, ext_sign=1, alu_op=2'b00 and pc_sel=0.
- R5: Opcode 0x2B (store) drives reg_dst=0, alu_src=1, mem_to_reg=0, reg_wr=0, mem_wr=1, ext_sign=1, alu_op=2'b00 and pc_sel=0.
- R6: Opcode 0x04 (branch on equal) drives reg_dst=0, alu_src=0, mem_to_reg=0, reg_wr=0, mem_wr=0, ext_sign=1 and alu_op=2'b01. It drives pc_sel equal to alu_zero.
- R7: For every opcode other than 0x04, pc_sel is 0 whatever the value of alu_zero.
- R8: The all-zero word is produced in two cases: an opcode outside {0x00, 0x0D, 0x23, 0x2B, 0x04}, and opcode 0x00 with a funct other than 0x21 or 0x23. In that word reg_wr, mem_wr and pc_sel are 0, and so are all the other outputs.
- R9: For every opcode other than 0x00, the funct input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode field of the instruction |
| funct | input | 6 | Function field, meaningful only when opcode is 0x00 |
| alu_zero | input | 1 | ALU result-is-zero flag |
| reg_dst | output | 1 | 1 selects the rd field as write register, 0 selects rt |
| alu_src | output | 1 | 1 feeds the extended immediate to ALU input B, 0 feeds register B |
| mem_to_reg | output | 1 | 1 writes memory data back, 0 writes the ALU result |
| reg_wr | output | 1 | Register file write enable |
| mem_wr | output | 1 | Data memory write enable |
| ext_sign | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |
| pc_sel | output | 1 | 1 takes the branch target, 0 advances to PC+4 |

## Verification
The case that is hardest to reach is an illegal function code under the register-format opcode. The opcode alone looks legal there, so the failure shows only when every funct value is swept while the opcode is held at 0x00. The stimulus therefore runs all 64 function codes under opcode 0x00, and it does so with both values of the zero flag. It also sweeps all 64 opcodes with several function values and both zero-flag values. That sweep shows up any leak of funct or alu_zero into instructions that must ignore them, and it shows up a branch that fires without a zero result.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ALUOP_W = 2;

  localparam logic [OP_W-1:0] OPC_RTYPE  = 6'h00;
  localparam logic [OP_W-1:0] OPC_ORIMM  = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'h04;

  localparam logic [FN_W-1:0] FN_ADD = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB = 6'h23;

  typedef enum logic [2:0] {
    K_ILLEGAL = 3'd0,
    K_ADD     = 3'd1,
    K_SUB     = 3'd2,
    K_ORIMM   = 3'd3,
    K_LOAD    = 3'd4,
    K_STORE   = 3'd5,
    K_BRANCH  = 3'd6
  } instr_kind_e;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_wr;
    logic    mem_wr;
    logic    ext_sign;
    alu_op_e alu_op;
    logic    is_branch;
  } ctrl_word_t;

  localparam ctrl_word_t CTRL_QUIET = '{reg_dst: 1'b0, alu_src: 1'b0,
    mem_to_reg: 1'b0, reg_wr: 1'b0, mem_wr: 1'b0, ext_sign: 1'b0,
    alu_op: ALU_ADD, is_branch: 1'b0};

  // Opcode and function field to instruction kind.
  function automatic instr_kind_e classify(input logic [OP_W-1:0] op,
                                           input logic [FN_W-1:0] fn);
    instr_kind_e k;
    k = K_ILLEGAL;
    case (op)
      OPC_RTYPE: begin
        if (fn == FN_ADD)      k = K_ADD;
        else if (fn == FN_SUB) k = K_SUB;
        else                   k = K_ILLEGAL;
      end
      OPC_ORIMM:  k = K_ORIMM;
      OPC_LOAD:   k = K_LOAD;
      OPC_STORE:  k = K_STORE;
      OPC_BRANCH: k = K_BRANCH;
      default:    k = K_ILLEGAL;
    endcase
    return k;
  endfunction

  // Instruction kind to full control word.
  function automatic ctrl_word_t control_for(input instr_kind_e k);
    ctrl_word_t w;
    w = CTRL_QUIET;
    case (k)
      K_ADD: begin
        w.reg_dst = 1'b1; w.reg_wr = 1'b1; w.alu_op = ALU_ADD;
      end
      K_SUB: begin
        w.reg_dst = 1'b1; w.reg_wr = 1'b1; w.alu_op = ALU_SUB;
      end
      K_ORIMM: begin
        w.alu_src = 1'b1; w.reg_wr = 1'b1; w.alu_op = ALU_OR;
      end
      K_LOAD: begin
        w.alu_src = 1'b1; w.mem_to_reg = 1'b1; w.reg_wr = 1'b1;
        w.ext_sign = 1'b1; w.alu_op = ALU_ADD;
      end
      K_STORE: begin
        w.alu_src = 1'b1; w.mem_wr = 1'b1; w.ext_sign = 1'b1;
        w.alu_op = ALU_ADD;
      end
      K_BRANCH: begin
        w.ext_sign = 1'b1; w.alu_op = ALU_SUB; w.is_branch = 1'b1;
      end
      default: w = CTRL_QUIET;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/instr_classify.sv
module instr_classify
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output instr_kind_e     kind,
  output logic            illegal
);
  always_comb begin
    kind    = classify(opcode, funct);
    illegal = (kind == K_ILLEGAL);
  end
endmodule

// File: rtl/ctrl_table.sv
module ctrl_table
  import ctrl_pkg::*;
(
  input  instr_kind_e kind,
  output ctrl_word_t  word
);
  always_comb word = control_for(kind);
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve (
  input  logic is_branch,
  input  logic alu_zero,
  output logic take
);
  assign take = is_branch & alu_zero;
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0]    opcode,
  input  logic [FN_W-1:0]    funct,
  input  logic               alu_zero,
  output logic               reg_dst,
  output logic               alu_src,
  output logic               mem_to_reg,
  output logic               reg_wr,
  output logic               mem_wr,
  output logic               ext_sign,
  output logic [ALUOP_W-1:0] alu_op,
  output logic               pc_sel
);
  instr_kind_e kind;
  logic        cls_illegal;
  ctrl_word_t  word;
  logic        take_branch;

  instr_classify u_cls (
    .opcode (opcode),
    .funct  (funct),
    .kind   (kind),
    .illegal(cls_illegal)
  );

  ctrl_table u_tab (
    .kind(kind),
    .word(word)
  );

  branch_resolve u_br (
    .is_branch(word.is_branch),
    .alu_zero (alu_zero),
    .take     (take_branch)
  );

  assign reg_dst    = word.reg_dst;
  assign alu_src    = word.alu_src;
  assign mem_to_reg = word.mem_to_reg;
  assign reg_wr     = word.reg_wr;
  assign mem_wr     = word.mem_wr;
  assign ext_sign   = word.ext_sign;
  assign alu_op     = word.alu_op;
  assign pc_sel     = take_branch;
endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk
  import ctrl_pkg::*;
(
  input logic               alu_zero,
  input logic               cls_illegal,
  input logic               alu_src,
  input logic               mem_to_reg,
  input logic               reg_wr,
  input logic               mem_wr,
  input logic               ext_sign,
  input logic [ALUOP_W-1:0] alu_op,
  input logic               pc_sel
);
  always_comb begin
    // R5: a memory write never comes with a register write
    a_r5_store_no_regwr: assert (!(mem_wr && reg_wr));
    // R6: the branch is taken only on a zero result
    a_r6_taken_needs_zero: assert (!pc_sel || alu_zero);
    // R4: a memory writeback always writes the register file
    a_r4_memdata_written: assert (!mem_to_reg || reg_wr);
    // R8: an unrecognised code drives no update
    a_r8_illegal_quiet: assert (!cls_illegal || (!reg_wr && !mem_wr && !pc_sel));
    // R3: a zero-extended immediate writeback is an OR
    a_r3_zext_is_or: assert (!(reg_wr && alu_src && !ext_sign) || alu_op == 2'b10);
  end
endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
  .alu_zero   (alu_zero),
  .cls_illegal(cls_illegal),
  .alu_src    (alu_src),
  .mem_to_reg (mem_to_reg),
  .reg_wr     (reg_wr),
  .mem_wr     (mem_wr),
  .ext_sign   (ext_sign),
  .alu_op     (alu_op),
  .pc_sel     (pc_sel)
);

// File: tb/ctrl_decoder_test.sv
module ctrl_decoder_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h00;
  logic       alu_zero = 1'b0;
  logic       reg_dst, alu_src, mem_to_reg, reg_wr, mem_wr, ext_sign, pc_sel;
  logic [1:0] alu_op;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [8:0] v;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  ctrl_decoder uut (
    .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .mem_wr(mem_wr), .ext_sign(ext_sign),
    .alu_op(alu_op), .pc_sel(pc_sel)
  );

  // Reference model, bit order {dst,src,m2r,rwr,mwr,ext,op[1:0],pc}
  function automatic item_t model(input logic [5:0] op, input logic [5:0] fn,
                                  input logic z);
    item_t it;
    if (op == 6'h00 && fn == 6'h21) begin
      it.v = 9'b1_0_0_1_0_0_00_0; it.tag = "R1";
    end else if (op == 6'h00 && fn == 6'h23) begin
      it.v = 9'b1_0_0_1_0_0_01_0; it.tag = "R2";
    end else if (op == 6'h0D) begin
      it.v = 9'b0_1_0_1_0_0_10_0; it.tag = "R3/R9";
    end else if (op == 6'h23) begin
      it.v = 9'b0_1_1_1_0_1_00_0; it.tag = "R4/R9";
    end else if (op == 6'h2B) begin
      it.v = 9'b0_1_0_0_1_1_00_0; it.tag = "R5/R9";
    end else if (op == 6'h04) begin
      it.v = {8'b0_0_0_0_0_1_01, z}; it.tag = "R6/R9";
    end else begin
      it.v = 9'b0; it.tag = "R8";
    end
    if (op != 6'h04 && it.tag != "R8") it.tag = {it.tag, "/R7"};
    return it;
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z);
    @(posedge clk);
    opcode = op; funct = fn; alu_zero = z;
    exp_q.push_back(model(op, fn, z));
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && exp_q.size() > 0) begin
        item_t it;
        logic [8:0] got;
        it  = exp_q.pop_front();
        got = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_wr, ext_sign, alu_op, pc_sel};
        checks++;
        if (got !== it.v) begin
          fails++;
          $display("FAIL %s op=%h fn=%h z=%b actual=%b expected=%b",
                   it.tag, opcode, funct, alu_zero, got, it.v);
        end
      end
    end
  end

  // Driver
  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    apply(6'h00, 6'h00, 1'b0);           // R8 initial quiet word
    apply(6'h00, 6'h21, 1'b0);           // R1
    apply(6'h00, 6'h21, 1'b1);           // R1, R7
    apply(6'h00, 6'h23, 1'b0);           // R2
    apply(6'h00, 6'h23, 1'b1);           // R2, R7
    apply(6'h0D, 6'h21, 1'b1);           // R3, R9
    apply(6'h23, 6'h00, 1'b0);           // R4
    apply(6'h2B, 6'h3F, 1'b1);           // R5, R7
    apply(6'h04, 6'h00, 1'b0);           // R6 not taken
    apply(6'h04, 6'h23, 1'b1);           // R6 taken, R9
    apply(6'h3F, 6'h21, 1'b1);           // R8
    // R8: every funct under register format
    for (int f = 0; f < 64; f++)
      for (int z = 0; z < 2; z++)
        apply(6'h00, f[5:0], z[0]);
    // R7, R8, R9: every opcode with several funct values
    for (int o = 0; o < 64; o++)
      for (int z = 0; z < 2; z++) begin
        apply(o[5:0], 6'h00, z[0]);
        apply(o[5:0], 6'h21, z[0]);
        apply(o[5:0], 6'h23, z[0]);
        apply(o[5:0], 6'h2A, z[0]);
      end
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule